// File: doc/BRIEF.md
# SCL Bit-Timing Generator

This block produces the serial clock timing for a two-wire bus master. It runs in two stages. A prescaler divides the system clock into an internal tick. A period counter then divides the tick stream into SCL periods. Each period has a fixed base of ticks, a programmable multiple of eight ticks, and a small rounding term. The rounding term covers the bus fall time, the bus rise time and the internal delay.

The period is split into a low phase and a high phase. During the low phase the block asks for SCL to be pulled low. It then releases the line and waits until the sensed SCL level is actually high. Only then does it start counting the high phase, so a slave can stretch the clock by holding the line low. A one-cycle strobe marks the middle of the low phase, where the master engine changes SDA. A second strobe marks the middle of the high phase, where the engine samples SDA. The divider settings are captured at the start of each period, so a change made mid-period never distorts a bit.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and while disabled after reset, `scl_low_o`, `scl_high_o`, `tick_o`, `sda_upd_o` and `sample_o` are all 0.
- R2: While enabled, `tick_o` pulses once every CDF+1 clock cycles, where CDF = `div_cfg_i[2:0]` (0 to 7). The prescaler restarts from zero at each period start.
- R3: One SCL period contains P = 20 + 8·SCGD + RND ticks, counted during the low and high phases only. Here SCGD = `div_cfg_i[8:3]` (0 to 63) and RND = `rnd_i`.
- R4: The low phase lasts L = P − floor(P/2) ticks, and `scl_low_o` is 1 throughout it. The first low phase after enabling therefore lasts L·(CDF+1) cycles.
- R5: `sda_upd_o` pulses exactly once per low phase, on the tick with index floor(L/2), counting from 0.
- R6: `sample_o` pulses exactly once per high phase, on the tick with index floor(H/2), counting from 0, where H = floor(P/2).
- R7: After the low phase, SCL stays released (`scl_low_o` = 0) and `scl_high_o` stays 0 until `scl_sense_i` is sampled high. `scl_high_o` rises on the next clock after that sample.
- R8: `div_cfg_i` and `rnd_i` are captured only when enabling and at the end of each high phase. A change at any other time does not affect the current period.
- R9: The clock after `en_i` is sampled low, all outputs are 0 and the counters are cleared. Re-enabling starts a fresh low phase with the current settings.
- R10: `scl_low_o` and `scl_high_o` are never 1 together, and each strobe occurs only on a tick within its own phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| div_cfg_i | input | 9 | Divider setting: [2:0] prescale CDF, [8:3] period multiplier SCGD |
| rnd_i | input | 4 | Rise/fall rounding term, in ticks |
| scl_sense_i | input | 1 | Sensed SCL line level |
| scl_low_o | output | 1 | Pull SCL low (low phase) |
| scl_high_o | output | 1 | High phase is being counted |
| tick_o | output | 1 | Internal tick strobe |
| sda_upd_o | output | 1 | Mid-low strobe for SDA changes |
| sample_o | output | 1 | Mid-high strobe for SDA sampling |

## Verification
The assertions check, on every cycle, the properties that need no memory of the period:
- the low and high phases never overlap;
- each strobe falls on a tick inside its own phase;
- the low phase always hands over to the released wait state;
- the high phase only begins after the line was sensed high;
- disabling empties the outputs within one clock.

The bench's reference model and its scenarios are needed for the arithmetic and timing:
- tick spacing for each prescale value;
- exact tick counts per period and the low/high split for odd periods;
- the position of the two strobes;
- a 40-cycle stretch held by the far end;
- a mid-period setting change that must wait for the next boundary.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_st_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CDF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CDF_W-1:0] cdf_i,
  output logic             tick_o
);
  logic [CDF_W-1:0] pre_q;

  assign tick_o = run_i && (pre_q >= cdf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/scl_period_cfg.sv
module scl_period_cfg #(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int RND_W      = 4,
  parameter int BASE_TICKS = 20,
  parameter int SCGD_STEP  = 8,
  parameter int PER_W      = 10,
  localparam int DIV_W     = CDF_W + SCGD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [CDF_W-1:0] cdf_o,
  output logic [PER_W-1:0] lo_len_o,
  output logic [PER_W-1:0] hi_len_o,
  output logic [PER_W-1:0] lo_mid_o,
  output logic [PER_W-1:0] hi_mid_o
);
  logic [CDF_W-1:0]  cdf_q;
  logic [SCGD_W-1:0] scgd_q;
  logic [RND_W-1:0]  rnd_q;
  logic [PER_W-1:0]  per;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cdf_q  <= '0;
      scgd_q <= '0;
      rnd_q  <= '0;
    end else if (load_i) begin
      cdf_q  <= div_cfg_i[CDF_W-1:0];
      scgd_q <= div_cfg_i[DIV_W-1:CDF_W];
      rnd_q  <= rnd_i;
    end
  end

  assign per      = PER_W'(BASE_TICKS) + PER_W'(scgd_q) * PER_W'(SCGD_STEP) + PER_W'(rnd_q);
  assign hi_len_o = per >> 1;
  assign lo_len_o = per - hi_len_o;
  assign lo_mid_o = lo_len_o >> 1;
  assign hi_mid_o = hi_len_o >> 1;
  assign cdf_o    = cdf_q;
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             scl_sense_i,
  input  logic [PER_W-1:0] lo_len_i,
  input  logic [PER_W-1:0] hi_len_i,
  input  logic [PER_W-1:0] lo_mid_i,
  input  logic [PER_W-1:0] hi_mid_i,
  output scl_st_e          state_o,
  output logic             load_o,
  output logic             sda_upd_o,
  output logic             sample_o
);
  scl_st_e          st_q, st_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             lo_last, hi_last;

  assign lo_last = cnt_q == (lo_len_i - PER_W'(1));
  assign hi_last = cnt_q == (hi_len_i - PER_W'(1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    load_o = 1'b0;
    if (st_q == ST_IDLE) begin
      cnt_d = '0;
      if (en_i) begin
        st_d   = ST_LOW;
        load_o = 1'b1;
      end
    end else if (!en_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_LOW: if (tick_i) begin
          if (lo_last) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        // high count starts only once the line is really high
        ST_WAIT: if (scl_sense_i) begin
          st_d  = ST_HIGH;
          cnt_d = '0;
        end
        ST_HIGH: if (tick_i) begin
          if (hi_last) begin
            st_d   = ST_LOW;
            cnt_d  = '0;
            load_o = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o   = st_q;
  assign sda_upd_o = tick_i && (st_q == ST_LOW)  && (cnt_q == lo_mid_i);
  assign sample_o  = tick_i && (st_q == ST_HIGH) && (cnt_q == hi_mid_i);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int RND_W      = 4,
  parameter int BASE_TICKS = 20,
  parameter int SCGD_STEP  = 8,
  localparam int DIV_W     = CDF_W + SCGD_W,
  localparam int PER_MAX   = BASE_TICKS + SCGD_STEP * ((1 << SCGD_W) - 1) + (1 << RND_W) - 1,
  localparam int PER_W     = $clog2(PER_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [RND_W-1:0] rnd_i,
  input  logic             scl_sense_i,
  output logic             scl_low_o,
  output logic             scl_high_o,
  output logic             tick_o,
  output logic             sda_upd_o,
  output logic             sample_o
);
  scl_st_e          state;
  logic             load, tick;
  logic [CDF_W-1:0] cdf_act;
  logic [PER_W-1:0] lo_len, hi_len, lo_mid, hi_mid;

  scl_period_cfg #(
    .CDF_W(CDF_W), .SCGD_W(SCGD_W), .RND_W(RND_W),
    .BASE_TICKS(BASE_TICKS), .SCGD_STEP(SCGD_STEP), .PER_W(PER_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .load_i(load), .div_cfg_i, .rnd_i,
    .cdf_o(cdf_act), .lo_len_o(lo_len), .hi_len_o(hi_len),
    .lo_mid_o(lo_mid), .hi_mid_o(hi_mid)
  );

  scl_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i(state != ST_IDLE), .cdf_i(cdf_act), .tick_o(tick)
  );

  scl_phase_fsm #(.PER_W(PER_W)) u_fsm (
    .clk_i, .rst_ni, .en_i,
    .tick_i(tick), .scl_sense_i,
    .lo_len_i(lo_len), .hi_len_i(hi_len), .lo_mid_i(lo_mid), .hi_mid_i(hi_mid),
    .state_o(state), .load_o(load), .sda_upd_o, .sample_o
  );

  assign scl_low_o  = state == ST_LOW;
  assign scl_high_o = state == ST_HIGH;
  assign tick_o     = tick;
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_sense_i,
  input logic scl_low_o,
  input logic scl_high_o,
  input logic tick_o,
  input logic sda_upd_o,
  input logic sample_o
);
  p_phase_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_low_o && scl_high_o));

  p_sda_in_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_upd_o |-> (tick_o && scl_low_o));

  p_sample_in_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (tick_o && scl_high_o));

  p_low_releases_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_low_o && en_i) |=> (scl_low_o || !scl_high_o));

  p_high_after_sense_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_high_o && !scl_sense_i) |=> !scl_high_o);

  p_disable_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_low_o && !scl_high_o && !tick_o && !sda_upd_o && !sample_o));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scl_sense_i(scl_sense_i),
  .scl_low_o(scl_low_o), .scl_high_o(scl_high_o), .tick_o(tick_o),
  .sda_upd_o(sda_upd_o), .sample_o(sample_o)
);

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [8:0] div_cfg = '0;
  logic [3:0] rnd = '0;
  logic       stretch = 1'b0;
  logic       scl_sense;
  logic       scl_low, scl_high, tick, sda_upd, sample;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_sense = !scl_low && !stretch;

  scl_timing_gen u_scl_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_cfg_i(div_cfg), .rnd_i(rnd),
    .scl_sense_i(scl_sense), .scl_low_o(scl_low), .scl_high_o(scl_high),
    .tick_o(tick), .sda_upd_o(sda_upd), .sample_o(sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference: 0 idle, 1 low, 2 wait, 3 high
  int m_st, m_pre, m_cnt, m_cdf, m_scgd, m_rnd;

  function automatic int m_hi();
    return (20 + 8 * m_scgd + m_rnd) / 2;
  endfunction
  function automatic int m_lo();
    return (20 + 8 * m_scgd + m_rnd) - m_hi();
  endfunction
  function automatic bit m_tick();
    return (m_st != 0) && (m_pre >= m_cdf);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pre = 0; m_cnt = 0; m_cdf = 0; m_scgd = 0; m_rnd = 0;
    end else begin
      bit tk, ld;
      tk = m_tick();
      ld = 1'b0;
      if (m_st == 0) begin
        m_pre = 0; m_cnt = 0;
        if (en) begin m_st = 1; ld = 1'b1; end
      end else if (!en) begin
        m_st = 0; m_pre = 0; m_cnt = 0;
      end else begin
        if (m_st == 1 && tk) begin
          if (m_cnt == m_lo() - 1) begin m_st = 2; m_cnt = 0; end
          else m_cnt++;
        end else if (m_st == 2) begin
          if (scl_sense) begin m_st = 3; m_cnt = 0; end
        end else if (m_st == 3 && tk) begin
          if (m_cnt == m_hi() - 1) begin m_st = 1; m_cnt = 0; ld = 1'b1; end
          else m_cnt++;
        end
        m_pre = tk ? 0 : m_pre + 1;
      end
      if (ld) begin
        m_cdf = int'(div_cfg[2:0]); m_scgd = int'(div_cfg[8:3]); m_rnd = int'(rnd);
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit tk;
      tk = m_tick();
      chk(scl_low == (m_st == 1), "R4 scl_low", scl_low, m_st == 1);
      chk(scl_high == (m_st == 3), "R7 scl_high", scl_high, m_st == 3);
      chk(tick == tk, "R2 tick", tick, tk);
      chk(sda_upd == (tk && m_st == 1 && m_cnt == m_lo() / 2), "R5 sda_upd", sda_upd,
          tk && m_st == 1 && m_cnt == m_lo() / 2);
      chk(sample == (tk && m_st == 3 && m_cnt == m_hi() / 2), "R6 sample", sample,
          tk && m_st == 3 && m_cnt == m_hi() / 2);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  // starts on the first negedge of a low phase, ends on the first of the next
  task automatic measure_period(output int lo_cyc, output int tk_cnt,
                                output int su_cnt, output int sp_cnt);
    lo_cyc = 0; tk_cnt = 0; su_cnt = 0; sp_cnt = 0;
    while (scl_low) begin
      lo_cyc++;
      tk_cnt += int'(tick);
      su_cnt += int'(sda_upd);
      @(negedge clk);
    end
    while (!scl_low) begin
      if (scl_high) tk_cnt += int'(tick);
      sp_cnt += int'(sample);
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input string req);
    chk(!scl_low && !scl_high && !tick && !sda_upd && !sample, req,
        {scl_low, scl_high, tick, sda_upd, sample}, 0);
  endtask

  initial begin
    int lo_c, tk_c, su_c, sp_c;
    // R1: outputs quiet in reset and while disabled
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 disabled after reset");

    // cfg A: cdf 0, scgd 0, rnd 0 -> P=20, L=10
    div_cfg = {6'd0, 3'd0}; rnd = 4'd0; en = 1'b1;
    @(negedge clk);
    // R8: cfg B written mid-period, first period stays on A
    div_cfg = {6'd1, 3'd2}; rnd = 4'd3;
    measure_period(lo_c, tk_c, su_c, sp_c);
    chk(lo_c == 10, "R4 low cycles cfg A", lo_c, 10);
    chk(tk_c == 20, "R3 R8 ticks cfg A", tk_c, 20);
    chk(su_c == 1, "R5 sda strobes", su_c, 1);
    chk(sp_c == 1, "R6 sample strobes", sp_c, 1);

    // cfg B: cdf 2, scgd 1, rnd 3 -> P=31, L=16, 48 cycles
    measure_period(lo_c, tk_c, su_c, sp_c);
    chk(lo_c == 48, "R2 R8 low cycles cfg B", lo_c, 48);
    chk(tk_c == 31, "R3 ticks cfg B", tk_c, 31);
    chk(su_c == 1, "R5 sda strobes cfg B", su_c, 1);
    chk(sp_c == 1, "R6 sample strobes cfg B", sp_c, 1);

    // R7: far end holds SCL low after the low phase
    stretch = 1'b1;
    while (scl_low) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      chk(!scl_high && !scl_low, "R7 stretch holds", {scl_high, scl_low}, 0);
      @(negedge clk);
    end
    stretch = 1'b0;
    @(negedge clk);
    chk(scl_high, "R7 high after release", scl_high, 1);

    // R9: disable mid-high
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_idle("R9 disable");
    div_cfg = {6'd3, 3'd1}; rnd = 4'd15;   // P=59, L=30, 60 cycles
    repeat (3) @(negedge clk);
    check_idle("R9 held off");
    en = 1'b1;
    @(negedge clk);
    chk(scl_low, "R9 fresh low", scl_low, 1);
    measure_period(lo_c, tk_c, su_c, sp_c);
    chk(lo_c == 60, "R9 R2 low cycles cfg C", lo_c, 60);
    chk(tk_c == 59, "R3 ticks cfg C", tk_c, 59);
    chk(su_c == 1 && sp_c == 1, "R10 one strobe each", su_c + sp_c, 2);

    en = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R9 final idle");
    finish_run();
  end
endmodule